// File: doc/BRIEF.md
# Fractional Bit-Clock and Frame-Sync Generator

This block derives a serial bit-clock rate from a faster master clock. The ratio is any rational N/M, with N and M each 16 bits wide. It never creates a second clock. Instead, it issues single-cycle enable pulses in the master clock domain, so downstream serial logic runs on the master clock and shifts only on those pulses.

Because N and M are arbitrary, both common master frequencies can reach the usual audio frame rates:
- From 22.5792 MHz, N=80 and M=441 give 4.096 MHz, which is 32 kHz at 128 bits per frame.
- From 24.576 MHz, N=147 and M=640 give 44.1 kHz, N=1 and M=4 give 48 kHz, and N=1 and M=1 give 192 kHz, each at 128 bits per frame.

Alongside the enable, the block keeps a bit position within the frame. The frame length is a programmed value plus one. From that position it drives a frame-sync level whose active phase opens each frame, and one control bit chooses whether that phase is high or low. Settings that cannot produce a valid rate are flagged, and no enables are produced while they stand.

Top module: `frac_bitclk_gen`

## Requirements
- R1: Counting master clock edges after reset is released as k = 1, 2, and so on, the output `bit_en` is high in the cycle after edge k exactly when floor(k·N/M) > floor((k−1)·N/M). Each pulse is therefore one cycle wide, and after k edges there have been exactly floor(k·N/M) pulses.
- R2: When N equals M (and both are nonzero), `bit_en` is high in every cycle after reset is released.
- R3: `bit_idx` changes only in a cycle where `bit_en` is high. It rises by one on each pulse and returns to 0 on the pulse that follows the value `frame_len_m1`, or any larger value.
- R4: A frame spans `frame_len_m1` + 1 enable pulses. Value 0 gives a one-bit frame, and value 127 gives 128 bits.
- R5: `fsync` is at its active level while `bit_idx` < floor((`frame_len_m1`+1)/2), and at the opposite level otherwise. The active level is high when `sync_start_high` is 1 and low when it is 0.
- R6: `cfg_err` is 1 when N is 0, when M is 0, or when N > M, and is 0 otherwise. While it is 1, `bit_en` stays low, `bit_idx` holds its value, and the rate accumulator is cleared.
- R7: While `rst_n` is low, `bit_en` is 0 and `bit_idx` is 0, and `fsync` follows the rule in R5 for position 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ratio_num | input | 16 | Rate numerator N |
| ratio_den | input | 16 | Rate denominator M |
| frame_len_m1 | input | 11 | Bits per frame minus one |
| sync_start_high | input | 1 | 1: frame opens with sync high; 0: with sync low |
| bit_en | output | 1 | One-cycle bit-clock enable |
| fsync | output | 1 | Frame-sync level |
| bit_idx | output | 11 | Bit position within the current frame |
| cfg_err | output | 1 | Illegal ratio setting |

## Verification
The accumulator's remainder cannot be seen at the ports. If it goes wrong, the effect is a pulse that arrives one master cycle early or late compared with floor(k·N/M). Comparing every cycle against that closed form therefore exposes the fault on the first misplaced pulse, not only as a drift in the average rate. A wrong bit position shows up at the next pulse as a `bit_idx` value that breaks the one-step sequence or wraps at the wrong place. Because `fsync` depends only on the position, a fault there also appears as a misplaced `fsync` edge within the same frame.

// File: rtl/frac_bitclk_gen.sv
module frac_bitclk_gen #(
  parameter int RW = 16,
  parameter int FW = 11
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [RW-1:0] ratio_num,
  input  logic [RW-1:0] ratio_den,
  input  logic [FW-1:0] frame_len_m1,
  input  logic          sync_start_high,
  output logic          bit_en,
  output logic          fsync,
  output logic [FW-1:0] bit_idx,
  output logic          cfg_err
);
  logic [RW:0] acc, sum;
  logic [FW:0] half;
  logic        hit, lead;

  assign cfg_err = (ratio_num == '0) || (ratio_den == '0) || (ratio_num > ratio_den);
  assign sum     = acc + {1'b0, ratio_num};
  assign hit     = !cfg_err && (sum >= {1'b0, ratio_den});
  assign half    = ({1'b0, frame_len_m1} + (FW+1)'(1)) >> 1;
  assign lead    = {1'b0, bit_idx} < half;
  assign fsync   = sync_start_high ? lead : !lead;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc     <= '0;
      bit_en  <= 1'b0;
      bit_idx <= '0;
    end else if (cfg_err) begin
      acc     <= '0;
      bit_en  <= 1'b0;
    end else begin
      bit_en <= hit;
      acc    <= hit ? sum - {1'b0, ratio_den} : sum;
      if (hit)
        bit_idx <= (bit_idx >= frame_len_m1) ? '0 : bit_idx + FW'(1);
    end
  end
endmodule

module frac_bitclk_gen_chk #(
  parameter int RW = 16,
  parameter int FW = 11
) (
  input logic          clk,
  input logic          rst_n,
  input logic [RW-1:0] ratio_num,
  input logic [RW-1:0] ratio_den,
  input logic [FW-1:0] frame_len_m1,
  input logic          sync_start_high,
  input logic          bit_en,
  input logic          fsync,
  input logic [FW-1:0] bit_idx,
  input logic          cfg_err
);
  a_r6_quiet_on_err: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err && $past(cfg_err) |-> !bit_en && $stable(bit_idx));

  a_r2_full_rate: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_err && ratio_num == ratio_den |=> bit_en);

  a_r3_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_en |-> $stable(bit_idx));

  a_r3_step: assert property (@(posedge clk) disable iff (!rst_n)
    bit_en && bit_idx != '0 |-> bit_idx == $past(bit_idx) + FW'(1));

  a_r4_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    bit_en && bit_idx == '0 |-> $past(bit_idx) >= $past(frame_len_m1));

  a_r5_sync_moves_on_bit: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_en && $stable(frame_len_m1) && $stable(sync_start_high) |-> $stable(fsync));
endmodule

bind frac_bitclk_gen frac_bitclk_gen_chk #(.RW(RW), .FW(FW)) u_chk (
  .clk(clk), .rst_n(rst_n), .ratio_num(ratio_num), .ratio_den(ratio_den),
  .frame_len_m1(frame_len_m1), .sync_start_high(sync_start_high),
  .bit_en(bit_en), .fsync(fsync), .bit_idx(bit_idx), .cfg_err(cfg_err)
);

// File: tb/tb_frac_bitclk_gen.sv
`timescale 1ns/1ps
module tb_frac_bitclk_gen;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] ratio_num = 16'd1, ratio_den = 16'd4;
  logic [10:0] frame_len_m1 = 11'd127;
  logic        sync_start_high = 1'b1;
  logic        bit_en, fsync, cfg_err;
  logic [10:0] bit_idx;

  frac_bitclk_gen dut (
    .clk(clk), .rst_n(rst_n), .ratio_num(ratio_num), .ratio_den(ratio_den),
    .frame_len_m1(frame_len_m1), .sync_start_high(sync_start_high),
    .bit_en(bit_en), .fsync(fsync), .bit_idx(bit_idx), .cfg_err(cfg_err)
  );

  always #2 clk = ~clk;

  typedef struct {
    logic        en;
    logic        fs;
    logic        err;
    logic [10:0] idx;
    string       tag;
  } exp_t;

  exp_t q[$];
  int   n_chk = 0, n_fail = 0;
  bit   done = 1'b0;

  function automatic logic sync_lvl(longint idx, longint len, logic sh);
    return ((idx < len / 2) == sh);
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp, string what);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      check(e.tag, {31'd0, bit_en}, {31'd0, e.en}, "bit_en");
      check(e.tag, {21'd0, bit_idx}, {21'd0, e.idx}, "bit_idx");
      check(e.tag, {31'd0, fsync}, {31'd0, e.fs}, "fsync");
      check(e.tag, {31'd0, cfg_err}, {31'd0, e.err}, "cfg_err");
    end
  end

  task automatic run_cfg(input int n, input int m, input int lm1, input logic sh,
                         input int cycles, input string tag);
    longint len = longint'(lm1) + 1;
    logic   bad = (n == 0) || (m == 0) || (n > m);
    @(negedge clk);
    rst_n = 1'b0;
    ratio_num = 16'(n); ratio_den = 16'(m);
    frame_len_m1 = 11'(lm1); sync_start_high = sh;
    repeat (2) @(negedge clk);
    check({tag, " R7"}, {31'd0, bit_en}, 32'd0, "reset bit_en");
    check({tag, " R7"}, {21'd0, bit_idx}, 32'd0, "reset bit_idx");
    check({tag, " R7"}, {31'd0, fsync}, {31'd0, sync_lvl(0, len, sh)}, "reset fsync");
    rst_n = 1'b1;
    for (longint k = 1; k <= cycles; k++) begin
      exp_t e;
      longint c, p;
      @(posedge clk);
      if (bad) begin
        c = 0; p = 0;
      end else begin
        c = (k * n) / m;
        p = ((k - 1) * n) / m;
      end
      e.en  = (c != p);
      e.idx = 11'(c % len);
      e.fs  = sync_lvl(c % len, len, sh);
      e.err = bad;
      e.tag = tag;
      q.push_back(e);
    end
    @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    run_cfg(1, 4, 127, 1'b1, 1200, "R1/R3/R5 48k");
    run_cfg(80, 441, 127, 1'b1, 2500, "R1/R4 32k");
    run_cfg(147, 640, 127, 1'b0, 1500, "R1/R5 44k1 low-start");
    run_cfg(147, 160, 9, 1'b1, 600, "R1/R3 short frame");
    run_cfg(3, 7, 4, 1'b0, 400, "R4/R5 odd frame");
    run_cfg(1, 1, 7, 1'b1, 100, "R2 unity");
    run_cfg(65535, 65535, 0, 1'b1, 50, "R2/R4 max unity one-bit");
    run_cfg(65534, 65535, 3, 1'b0, 300, "R1 near unity");
    run_cfg(0, 5, 7, 1'b1, 60, "R6 zero num");
    run_cfg(5, 0, 7, 1'b0, 60, "R6 zero den");
    run_cfg(9, 8, 7, 1'b1, 60, "R6 num above den");
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule